// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Driver

This block shows two decimal digits at the same time on a four-position seven-segment display. All positions share one segment bus, and each position has its own enable line. The block accepts a tens value and a units value in BCD and decodes each one into a segment pattern. It lights one of the two rightmost positions at a time. A refresh timer swaps the lit position often enough that the eye sees both digits steadily.

The enable lines are active low. The units digit goes on the rightmost position, enable pattern `1110`, and the tens digit goes on the position to its left, pattern `1101`. The two leftmost positions are never lit. Segments are active low, with segment a on bit 0 up to segment g on bit 6. Under this encoding zero is `1000000` and one is `1111001`.

The segment bus and the enable vector are updated from one output register in the same cycle. As a result, a lit position never carries the other digit's pattern. At the default setting of `TICK_CYCLES = 100000` and a 100 MHz clock, each digit is lit for 1 ms, and a full refresh takes 2 ms.

Top module: `disp_mux2_drv`

## Requirements
- R1: While `rst_n` is low, `dig_en_n` is `1111` and `seg_n` is `1111111`.
- R2: At most one bit of `dig_en_n` is low in any cycle. After the first clock edge following reset release, exactly one bit is low.
- R3: `dig_en_n[3]` and `dig_en_n[2]` are always 1, so the two leftmost positions stay blank.
- R4: Enable pattern `1110` carries the units digit and pattern `1101` carries the tens digit. The first position lit after reset is the units digit.
- R5: For a BCD value d from 0 to 9, `seg_n` is the bitwise inverse of the lit set of d, where bit i is segment a+i. The lit sets are: 0 → a b c d e f; 1 → b c; 2 → a b d e g; 3 → a b c d g; 4 → b c f g; 5 → a c d f g; 6 → a c d e f g; 7 → a b c; 8 → all; 9 → a b c d f g.
- R6: A BCD value from 10 to 15 on the digit being shown gives `seg_n = 1111111`.
- R7: Each position stays lit for exactly `TICK_CYCLES` cycles, and then the other position is lit.
- R8: `seg_n` and `dig_en_n` change on the same edge. In any cycle, `seg_n` shows the input value of the selected digit as it was at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tens_bcd | input | 4 | Tens digit, BCD |
| units_bcd | input | 4 | Units digit, BCD |
| seg_n | output | 7 | Shared segment bus, active low, bit 0 = a ... bit 6 = g |
| dig_en_n | output | 4 | Position enables, active low, bit 0 = rightmost |

## Verification
The assertions check on every cycle that no more than one position is enabled and that the two left positions stay dark. They also check that the scan select changes only on a refresh tick, that ticks are never back to back, and that an out-of-range units value blanks the bus. Only the bench scenarios can show the decoded patterns of all sixteen input codes on both positions, which digit goes on which position, and the exact dwell length. The bench does this by sweeping every tens and units pair against a cycle-counted model of the scan.

// File: rtl/disp_mux2_pkg.sv
package disp_mux2_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;
  localparam int POS_N = 4;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [POS_N-1:0] pos_t;

  localparam seg_t SEG_DARK   = '1;
  localparam pos_t EN_NONE    = '1;
  localparam pos_t EN_UNITS   = 4'b1110;
  localparam pos_t EN_TENS    = 4'b1101;

  // Active-low pattern, bit 0 = segment a ... bit 6 = segment g.
  function automatic seg_t bcd_to_seg(input bcd_t v);
    seg_t lit;
    case (v)
      4'd0: lit = 7'b0111111;
      4'd1: lit = 7'b0000110;
      4'd2: lit = 7'b1011011;
      4'd3: lit = 7'b1001111;
      4'd4: lit = 7'b1100110;
      4'd5: lit = 7'b1101101;
      4'd6: lit = 7'b1111101;
      4'd7: lit = 7'b0000111;
      4'd8: lit = 7'b1111111;
      4'd9: lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
    return ~lit;
  endfunction
endpackage

// File: rtl/disp_refresh_timer.sv
module disp_refresh_timer #(
  parameter int TICK_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R7: ticks are spaced, never on consecutive cycles
  p_tick_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/disp_digit_scan.sv
module disp_digit_scan (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic sel_tens
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_tens <= 1'b0;
    else if (tick) sel_tens <= ~sel_tens;
  end

  // R7: select swaps on a tick and holds otherwise
  p_swap_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (sel_tens != $past(sel_tens)));
  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sel_tens));
endmodule

// File: rtl/disp_seg_decoder.sv
module disp_seg_decoder
  import disp_mux2_pkg::*;
(
  input  bcd_t value,
  output seg_t seg_n
);
  assign seg_n = bcd_to_seg(value);
endmodule

// File: rtl/disp_mux2_drv.sv
module disp_mux2_drv
  import disp_mux2_pkg::*;
#(
  parameter int TICK_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tens_bcd,
  input  logic [3:0] units_bcd,
  output logic [6:0] seg_n,
  output logic [3:0] dig_en_n
);
  localparam int NDIG = 2;

  logic tick;
  logic sel_tens;
  bcd_t digit_val [NDIG];
  seg_t digit_seg [NDIG];

  assign digit_val[0] = units_bcd;
  assign digit_val[1] = tens_bcd;

  disp_refresh_timer #(.TICK_CYCLES(TICK_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  disp_digit_scan scan_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel_tens(sel_tens)
  );

  for (genvar g = 0; g < NDIG; g++) begin : g_dec
    disp_seg_decoder dec_i (.value(digit_val[g]), .seg_n(digit_seg[g]));
  end

  // One register drives both buses so they always change together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_en_n <= EN_NONE;
      seg_n    <= SEG_DARK;
    end else begin
      dig_en_n <= sel_tens ? EN_TENS : EN_UNITS;
      seg_n    <= digit_seg[sel_tens];
    end
  end

  // R2: never more than one position enabled
  p_one_position_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dig_en_n));
  // R3: left two positions stay dark
  p_left_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dig_en_n[3:2] == 2'b11);
  // R6: out-of-range units value blanks the bus on its position
  p_units_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en_n == EN_UNITS && $past(units_bcd) > 4'd9) |-> seg_n == SEG_DARK);
  // R6: out-of-range tens value blanks the bus on its position
  p_tens_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en_n == EN_TENS && $past(tens_bcd) > 4'd9) |-> seg_n == SEG_DARK);
endmodule

// File: tb/disp_mux2_drv_tb_top.sv
module disp_mux2_drv_tb_top;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tens_bcd = '0;
  logic [3:0] units_bcd = '0;
  logic [6:0] seg_n;
  logic [3:0] dig_en_n;

  int checks = 0;
  int fails = 0;
  int edges = 0;
  int run_len = 0;
  logic [3:0] last_en = 4'hF;
  logic [3:0] t_at_edge, u_at_edge;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disp_mux2_drv #(.TICK_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .tens_bcd(tens_bcd), .units_bcd(units_bcd),
    .seg_n(seg_n), .dig_en_n(dig_en_n)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] lit;
    // bit i = segment a+i; lit set per R5
    case (v)
      4'd0: lit = 7'h3F; 4'd1: lit = 7'h06; 4'd2: lit = 7'h5B;
      4'd3: lit = 7'h4F; 4'd4: lit = 7'h66; 4'd5: lit = 7'h6D;
      4'd6: lit = 7'h7D; 4'd7: lit = 7'h07; 4'd8: lit = 7'h7F;
      4'd9: lit = 7'h6F; default: lit = 7'h00;
    endcase
    return ~lit;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // One cycle: note inputs at the edge, then compare at the falling edge.
  task automatic cycle();
    logic [3:0] ee;
    logic [3:0] dv;
    @(posedge clk);
    t_at_edge = tens_bcd;
    u_at_edge = units_bcd;
    edges++;
    @(negedge clk);
    ee = ((((edges - 1) / T) % 2) == 1) ? 4'b1101 : 4'b1110;
    dv = (ee == 4'b1101) ? t_at_edge : u_at_edge;
    chk(dig_en_n == ee, "R4", {12'h0, dig_en_n}, {12'h0, ee});
    chk($countones(~dig_en_n) == 1, "R2", {12'h0, dig_en_n}, 16'h1);
    chk(dig_en_n[3:2] == 2'b11, "R3", {14'h0, dig_en_n[3:2]}, 16'h3);
    if (dv > 4'd9)
      chk(seg_n == 7'h7F, "R6", {9'h0, seg_n}, 16'h7F);
    else
      chk(seg_n == exp_seg(dv), "R5/R8", {9'h0, seg_n}, {9'h0, exp_seg(dv)});
    if (dig_en_n != last_en) begin
      if (last_en != 4'hF)
        chk(run_len == T, "R7", 16'(run_len), 16'(T));
      run_len = 1;
      last_en = dig_en_n;
    end else begin
      run_len++;
    end
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    chk(dig_en_n == 4'hF, "R1", {12'h0, dig_en_n}, 16'hF);
    chk(seg_n == 7'h7F, "R1", {9'h0, seg_n}, 16'h7F);
    rst_n = 1'b1;
    // Sweep every tens/units pair; inputs change at the falling edge,
    // mid-dwell, so R8 latency is exercised too.
    for (int t = 0; t < 16; t++) begin
      for (int u = 0; u < 16; u++) begin
        tens_bcd = 4'(t);
        units_bcd = 4'(u);
        repeat (2 * T + 1) cycle();
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule